// File: doc/BRIEF.md
# Segmented Block Stream Decoder

This block turns a segmented word stream back into AXI4-Stream frames. The input is a word of `SEG_CNT` segments, each `SEG_W` bits wide. Each segment has its own valid and ready. Within a word, bytes run little-endian from segment 0 upward. The stream is a sequence of blocks. Each block starts on a segment boundary with a small header, carries its payload bytes, and is padded out to the next segment boundary.

The decoder reads each header and validates the two parity bits in it. Null blocks and blocks that fail the parity check are thrown away, and a parity failure also pulses an error output. Payload bytes of the blocks that belong to one frame are packed tightly into output beats one segment wide. The header metadata drives the id, destination and user sidebands. The beat that carries the final byte of a block whose last flag is set is marked as the frame end.

Top module: `segstream_decoder`

## Requirements
- R1: A header occupies the low `(16 + ID_W + DEST_W + USER_W + 7) / 8` bytes (integer division) of the first segment of a block, read little-endian. The next header is read from the segment that follows the block's last segment, so a block of `n` payload bytes spans `ceil((header bytes + n) / segment bytes)` segments and its padding is never forwarded.
- R2: A block whose header bit 0 is 0 is a null block. It gives no output bytes and no error pulse, and the following header is still found after it.
- R3: The payload length is header bits 15:4 plus one. Exactly that many payload bytes of a data block are forwarded, in stream order.
- R4: Header bit 2 must equal bit 0 XOR bit 1, and header bit 3 must equal the XOR of bits 15:4. On a mismatch, `hdr_err_o` is high for exactly the one cycle after the header segment is accepted, and the whole block is discarded.
- R5: Header bits from 16 upward hold id (`ID_W` bits), then dest (`DEST_W` bits), then user (`USER_W` bits), from low to high. They appear on `m_tid`, `m_tdest` and `m_tuser` for the frame's beats.
- R6: Payload bytes of consecutive accepted data blocks are concatenated without gaps. `m_tlast` is high on the beat that holds the final byte of a block whose header bit 1 is set, and that beat holds no byte of the next frame.
- R7: Every beat except the frame's last has `m_tkeep` all ones. The last beat has `m_tkeep` set to contiguous ones from bit 0, one per valid byte, with byte 0 in `m_tdata[7:0]`.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` do not change.
- R9: At most one bit of `seg_ready_o` is high at any time. Segments are taken in order 0, 1, … `SEG_CNT-1`, then 0 again. Ready is held low while the internal buffer cannot take a full segment, so no input byte is lost under output stall.
- R10: In the cycles after reset, `m_tvalid` and `hdr_err_o` are low and only `seg_ready_o[0]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_data_i | input | SEG_CNT*SEG_W | Segmented input word, segment k at bits k*SEG_W |
| seg_valid_i | input | SEG_CNT | Per-segment valid |
| seg_ready_o | output | SEG_CNT | Per-segment ready |
| m_tdata | output | SEG_W | Output stream data |
| m_tkeep | output | SEG_W/8 | Output byte enables |
| m_tlast | output | 1 | Frame end |
| m_tid | output | ID_W | Stream id from header |
| m_tdest | output | DEST_W | Stream destination from header |
| m_tuser | output | USER_W | Stream user bits from header |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |
| hdr_err_o | output | 1 | One-cycle pulse on header parity mismatch |

## Verification
The stimulus mixes null blocks and blocks with a flipped parity bit (either bit 2 or bit 3) in among the blocks of real frames. A decoder that skipped the wrong number of segments after such a block would lose alignment and misread the next header, which corrupts every later beat. Payload lengths cover one byte, lengths that end exactly at a segment edge, and blocks that span several segments. An off-by-one length or forwarded padding therefore shows up as wrong bytes or a wrong keep on the final beat. Random output stall, together with gaps in input valid, tests that beats stay frozen while stalled and that no segment is taken when the buffer has no room. A wrong lane order would reorder bytes within a word.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
    // header bit positions that neighbouring logic decodes
    localparam int HB_DATA  = 0;
    localparam int HB_LAST  = 1;
    localparam int HB_PCTL  = 2;
    localparam int HB_PLEN  = 3;
    localparam int LEN_LO   = 4;
    localparam int LEN_W    = 12;
    localparam int META_LO  = 16;
    // remaining-byte counter: 4096 plus one guard bit
    localparam int REM_W    = LEN_W + 1;
endpackage

// File: rtl/seg_hdr_check.sv
module seg_hdr_check
    import segdec_pkg::*;
(
    input  logic [15:0]      hdr_i,
    output logic             is_data_o,
    output logic             is_last_o,
    output logic             par_ok_o,
    output logic [LEN_W-1:0] len_m1_o
);
    logic ctl_ok;
    logic len_ok;

    always_comb begin
        is_data_o = hdr_i[HB_DATA];
        is_last_o = hdr_i[HB_LAST];
        len_m1_o  = hdr_i[LEN_LO +: LEN_W];
        ctl_ok    = hdr_i[HB_PCTL] == (hdr_i[HB_DATA] ^ hdr_i[HB_LAST]);
        len_ok    = hdr_i[HB_PLEN] == (^hdr_i[LEN_LO +: LEN_W]);
        par_ok_o  = ctl_ok && len_ok;
    end
endmodule

// File: rtl/seg_byte_packer.sv
module seg_byte_packer #(
    parameter int BYTES  = 8,
    parameter int META_W = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push_valid_i,
    input  logic [BYTES*8-1:0]            push_data_i,
    input  logic [$clog2(2*BYTES+1)-1:0]  push_cnt_i,
    input  logic                          push_end_i,
    input  logic [META_W-1:0]             push_meta_i,
    output logic                          can_push_o,
    output logic                          out_valid_o,
    output logic [BYTES*8-1:0]            out_data_o,
    output logic [BYTES-1:0]              out_keep_o,
    output logic                          out_last_o,
    output logic [META_W-1:0]             out_meta_o,
    input  logic                          out_ready_i
);
    localparam int CNT_W = $clog2(2*BYTES+1);
    localparam int BUF_W = 2*BYTES*8;
    localparam logic [CNT_W-1:0] BEAT_N = CNT_W'(BYTES);

    typedef struct packed {
        logic [BUF_W-1:0]  store;
        logic [CNT_W-1:0]  cnt;
        logic              fin;
        logic [META_W-1:0] meta;
    } pk_t;

    pk_t q, d;

    logic             full_beat;
    logic [CNT_W-1:0] out_n;
    logic [CNT_W-1:0] pop_n;
    logic [CNT_W-1:0] cnt_p;
    logic [BUF_W-1:0] shifted;
    logic [BUF_W-1:0] incoming;

    always_comb begin
        d         = q;
        full_beat = q.cnt >= BEAT_N;
        out_valid_o = full_beat || (q.fin && (q.cnt != '0));
        out_n     = full_beat ? BEAT_N : q.cnt;
        out_last_o = q.fin && (q.cnt <= BEAT_N);
        for (int i = 0; i < BYTES; i++) begin
            out_keep_o[i] = CNT_W'(i) < out_n;
        end
        out_data_o = q.store[BYTES*8-1:0];
        out_meta_o = q.meta;
        can_push_o = !q.fin && (q.cnt <= BEAT_N);

        pop_n   = (out_valid_o && out_ready_i) ? out_n : '0;
        shifted = q.store >> {pop_n, 3'b000};
        cnt_p   = q.cnt - pop_n;
        if (out_valid_o && out_ready_i && out_last_o) begin
            d.fin = 1'b0;
        end

        incoming = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (CNT_W'(k) < push_cnt_i) begin
                incoming[k*8 +: 8] = push_data_i[k*8 +: 8];
            end
        end
        if (push_valid_i) begin
            shifted = shifted | (incoming << {cnt_p, 3'b000});
            cnt_p   = cnt_p + push_cnt_i;
            d.meta  = push_meta_i;
            if (push_end_i) begin
                d.fin = 1'b1;
            end
        end
        d.store = shifted;
        d.cnt   = cnt_p;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_KEEP_PACKED: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (out_keep_o != '0) && ((out_keep_o & (out_keep_o + 1'b1)) == '0)); // R7
    AST_MID_BEAT_FULL: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_last_o |-> &out_keep_o); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
            && $stable(out_keep_o) && $stable(out_last_o)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= CNT_W'(2*BYTES)); // R9
endmodule

// File: rtl/segstream_decoder.sv
module segstream_decoder
    import segdec_pkg::*;
#(
    parameter int SEG_CNT = 2,
    parameter int SEG_W   = 64,
    parameter int ID_W    = 4,
    parameter int DEST_W  = 4,
    parameter int USER_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEG_CNT*SEG_W-1:0] seg_data_i,
    input  logic [SEG_CNT-1:0]       seg_valid_i,
    output logic [SEG_CNT-1:0]       seg_ready_o,
    output logic [SEG_W-1:0]         m_tdata,
    output logic [SEG_W/8-1:0]       m_tkeep,
    output logic                     m_tlast,
    output logic [ID_W-1:0]          m_tid,
    output logic [DEST_W-1:0]        m_tdest,
    output logic [USER_W-1:0]        m_tuser,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    output logic                     hdr_err_o
);
    localparam int SB        = SEG_W / 8;
    localparam int META_W    = ID_W + DEST_W + USER_W;
    localparam int HDR_BYTES = (16 + META_W + 7) / 8;
    localparam int PTR_W     = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1;
    localparam int CNT_W     = $clog2(2*SB+1);
    localparam logic [REM_W-1:0] FIRST_ROOM = REM_W'(SB - HDR_BYTES);
    localparam logic [REM_W-1:0] SEG_ROOM   = REM_W'(SB);
    localparam logic [PTR_W-1:0] PTR_LAST   = PTR_W'(SEG_CNT - 1);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              in_blk;
        logic [REM_W-1:0]  rem;
        logic              drop;
        logic              blk_last;
        logic [META_W-1:0] meta;
        logic              err;
    } seq_t;

    seq_t q, d;

    logic [SEG_W-1:0]  cur_seg;
    logic              hs;
    logic              can_push;
    logic              h_data, h_last, h_par_ok;
    logic [LEN_W-1:0]  h_len_m1;
    logic [REM_W-1:0]  total;
    logic [REM_W-1:0]  take;
    logic [REM_W-1:0]  rem_n;
    logic              push_valid;
    logic [SEG_W-1:0]  push_data;
    logic [CNT_W-1:0]  push_cnt;
    logic              push_end;
    logic [META_W-1:0] push_meta;
    logic [META_W-1:0] out_meta;

    always_comb begin
        cur_seg = seg_data_i[int'(q.ptr)*SEG_W +: SEG_W];
        hs      = seg_valid_i[q.ptr] && can_push;
        for (int s = 0; s < SEG_CNT; s++) begin
            seg_ready_o[s] = can_push && (q.ptr == PTR_W'(s));
        end
    end

    seg_hdr_check u_hdr (
        .hdr_i     (cur_seg[15:0]),
        .is_data_o (h_data),
        .is_last_o (h_last),
        .par_ok_o  (h_par_ok),
        .len_m1_o  (h_len_m1)
    );

    always_comb begin
        d          = q;
        d.err      = 1'b0;
        total      = {1'b0, h_len_m1} + 1'b1;
        take       = '0;
        rem_n      = q.rem;
        push_valid = 1'b0;
        push_data  = cur_seg;
        push_end   = 1'b0;
        push_meta  = q.meta;
        if (hs) begin
            d.ptr = (q.ptr == PTR_LAST) ? '0 : q.ptr + 1'b1;
            if (!q.in_blk) begin
                take       = (total > FIRST_ROOM) ? FIRST_ROOM : total;
                rem_n      = total - take;
                d.drop     = !h_par_ok || !h_data;
                d.err      = !h_par_ok;
                d.blk_last = h_last;
                d.meta     = cur_seg[META_LO +: META_W];
                push_meta  = cur_seg[META_LO +: META_W];
                push_data  = cur_seg >> (HDR_BYTES*8);
                push_valid = h_par_ok && h_data;
                push_end   = h_par_ok && h_data && h_last && (rem_n == '0);
            end else begin
                take       = (q.rem > SEG_ROOM) ? SEG_ROOM : q.rem;
                rem_n      = q.rem - take;
                push_valid = !q.drop;
                push_end   = !q.drop && q.blk_last && (rem_n == '0);
            end
            d.rem    = rem_n;
            d.in_blk = rem_n != '0;
        end
        push_cnt = CNT_W'(take);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    seg_byte_packer #(
        .BYTES  (SB),
        .META_W (META_W)
    ) u_pack (
        .clk          (clk),
        .rst          (rst),
        .push_valid_i (push_valid),
        .push_data_i  (push_data),
        .push_cnt_i   (push_cnt),
        .push_end_i   (push_end),
        .push_meta_i  (push_meta),
        .can_push_o   (can_push),
        .out_valid_o  (m_tvalid),
        .out_data_o   (m_tdata),
        .out_keep_o   (m_tkeep),
        .out_last_o   (m_tlast),
        .out_meta_o   (out_meta),
        .out_ready_i  (m_tready)
    );

    assign m_tid     = out_meta[0 +: ID_W];
    assign m_tdest   = out_meta[ID_W +: DEST_W];
    assign m_tuser   = out_meta[ID_W+DEST_W +: USER_W];
    assign hdr_err_o = q.err;

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seg_ready_o)); // R9
    AST_ERR_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        hdr_err_o |-> $past(hs && !q.in_blk)); // R4
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        hs && !q.in_blk && !h_par_ok |=> !q.in_blk || q.drop); // R4
endmodule

// File: tb/segstream_decoder_test.sv
`timescale 1ns/1ps
module segstream_decoder_test;
    localparam int SEG_CNT = 2;
    localparam int SEG_W   = 64;
    localparam int SB      = SEG_W / 8;
    localparam int WB      = SEG_CNT * SB;

    logic                     clk = 1'b0;
    logic                     rst;
    logic [SEG_CNT*SEG_W-1:0] seg_data;
    logic [SEG_CNT-1:0]       seg_valid;
    logic [SEG_CNT-1:0]       seg_ready;
    logic [SEG_W-1:0]         tdata;
    logic [SB-1:0]            tkeep;
    logic                     tlast, tvalid, tready, err;
    logic [3:0]               tid, tdest;
    logic [1:0]               tuser;

    always #4 clk = ~clk;

    segstream_decoder uut (
        .clk(clk), .rst(rst), .seg_data_i(seg_data), .seg_valid_i(seg_valid),
        .seg_ready_o(seg_ready), .m_tdata(tdata), .m_tkeep(tkeep), .m_tlast(tlast),
        .m_tid(tid), .m_tdest(tdest), .m_tuser(tuser), .m_tvalid(tvalid),
        .m_tready(tready), .hdr_err_o(err)
    );

    byte unsigned   in_q[$];
    byte unsigned   pay_q[$];
    logic [63:0]    e_data[$];
    logic [7:0]     e_keep[$];
    bit             e_last[$];
    logic [9:0]     e_meta[$];
    int n_checks = 0, n_fail = 0, exp_err = 0, got_err = 0, hs_seg = 0;
    int beats_exp = 0, beats_got = 0;
    byte unsigned fbyte = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bad: 0 clean, 1 flip control parity, 2 flip length parity
    task automatic add_block(input int len, input bit dat, input bit lst, input int bad, input logic [9:0] meta);
        logic [31:0] h;
        h = '0;
        h[0] = dat;
        h[1] = lst;
        h[15:4] = 12'(len - 1);
        h[2] = h[0] ^ h[1];
        h[3] = ^h[15:4];
        if (bad == 1) h[2] = ~h[2];
        if (bad == 2) h[3] = ~h[3];
        h[25:16] = meta;
        for (int i = 0; i < 4; i++) in_q.push_back(h[i*8 +: 8]);
        for (int i = 0; i < len; i++) begin
            if (dat && bad == 0) in_q.push_back(pay_q.pop_front());
            else in_q.push_back(8'($urandom));
        end
        while ((in_q.size() % SB) != 0) in_q.push_back(8'hA5);
        if (bad != 0) exp_err++;
    endtask

    task automatic add_frame(input int flen, input int maxblk, input bit noise);
        logic [9:0] meta;
        byte unsigned fb[$];
        int rem, b;
        meta = 10'($urandom);
        for (int i = 0; i < flen; i++) begin
            fb.push_back(fbyte);
            pay_q.push_back(fbyte);
            fbyte++;
        end
        for (int off = 0; off < flen; off += SB) begin
            logic [63:0] dv;
            logic [7:0]  kv;
            dv = '0;
            kv = '0;
            for (int k = 0; k < SB; k++) begin
                if (off + k < flen) begin
                    dv[k*8 +: 8] = fb[off+k];
                    kv[k] = 1'b1;
                end
            end
            e_data.push_back(dv);
            e_keep.push_back(kv);
            e_last.push_back(off + SB >= flen);
            e_meta.push_back(meta);
            beats_exp++;
        end
        rem = flen;
        while (rem > 0) begin
            if (noise && ($urandom % 5) == 0)
                add_block(1 + int'($urandom % 20), 1'b0, 1'($urandom), 0, 10'($urandom)); // R2 null
            if (noise && ($urandom % 6) == 0)
                add_block(1 + int'($urandom % 20), 1'b1, 1'($urandom), 1 + int'($urandom % 2), 10'($urandom)); // R4 bad parity
            b = 1 + int'($urandom % maxblk);
            if (b > rem) b = rem;
            add_block(b, 1'b1, rem == b, 0, meta);
            rem -= b;
        end
    endtask

    task automatic run(input bit gaps, input bit bp);
        logic [SEG_CNT-1:0] pend = '0, hs_prev = '0;
        bit prev_stall = 0;
        logic [63:0] sv_d;
        logic [7:0]  sv_k;
        bit          sv_l;
        int wd = 0;
        while ((in_q.size() % WB) != 0) add_block(1, 1'b0, 1'b0, 0, '0);
        while ((in_q.size() > 0 || pend != '0 || e_data.size() > 0) && wd < 40000) begin
            @(negedge clk);
            wd++;
            pend = pend & ~hs_prev;
            if (pend == '0 && in_q.size() >= WB && (!gaps || ($urandom % 3) != 0)) begin
                for (int i = 0; i < WB; i++) seg_data[i*8 +: 8] = in_q.pop_front();
                pend = '1;
            end
            seg_valid = pend;
            if (seg_ready != '0)
                check(seg_ready == SEG_CNT'(1 << (hs_seg % SEG_CNT)), "R9 lane order", 64'(seg_ready), 64'(1 << (hs_seg % SEG_CNT)));
            hs_prev = seg_valid & seg_ready;
            hs_seg += $countones(hs_prev);
            if (err) got_err++;
            if (prev_stall) begin
                check(tvalid == 1'b1, "R8 valid held", 64'(tvalid), 64'd1);
                check(tdata == sv_d && tkeep == sv_k && tlast == sv_l, "R8 beat held", tdata, sv_d);
            end
            tready = bp ? (($urandom % 3) != 0) : 1'b1;
            if (tvalid && tready) begin
                beats_got++;
                if (e_data.size() == 0) begin
                    check(1'b0, "R6 unexpected beat", tdata, '0);
                end else begin
                    logic [63:0] ed, msk;
                    ed = e_data.pop_front();
                    msk = '0;
                    for (int k = 0; k < SB; k++) if (e_keep[0][k]) msk[k*8 +: 8] = 8'hFF;
                    check((tdata & msk) == ed, "R3 R6 payload bytes", tdata & msk, ed);
                    check(tkeep == e_keep[0], "R7 keep", 64'(tkeep), 64'(e_keep[0]));
                    check(tlast == e_last[0], "R6 last", 64'(tlast), 64'(e_last[0]));
                    check({tuser, tdest, tid} == e_meta[0], "R5 sidebands", 64'({tuser, tdest, tid}), 64'(e_meta[0]));
                    void'(e_keep.pop_front());
                    void'(e_last.pop_front());
                    void'(e_meta.pop_front());
                end
            end
            prev_stall = tvalid && !tready;
            sv_d = tdata;
            sv_k = tkeep;
            sv_l = tlast;
        end
        check(wd < 40000, "watchdog expired", 64'(wd), 64'd40000);
        @(negedge clk);
        seg_valid = '0;
        repeat (4) begin
            @(negedge clk);
            if (err) got_err++;
        end
    endtask

    initial begin
        rst = 1'b1;
        seg_valid = '0;
        seg_data = '0;
        tready = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tvalid == 1'b0, "R10 no beat after reset", 64'(tvalid), 64'd0);
        check(err == 1'b0, "R10 no error after reset", 64'(err), 64'd0);
        check(seg_ready == SEG_CNT'(1), "R10 lane zero ready", 64'(seg_ready), 64'd1);

        // phase 1: edge lengths, clean flow
        add_frame(1, 12, 1'b0);
        add_frame(4, 4, 1'b0);      // R1 payload ends at first segment edge
        add_frame(8, 8, 1'b0);      // R7 full last beat
        add_frame(16, 12, 1'b0);
        add_frame(12, 12, 1'b0);    // R1 block ends exactly at second segment edge
        for (int f = 0; f < 20; f++) add_frame(1 + int'($urandom % 40), 12, 1'b1);
        run(1'b0, 1'b0);

        // phase 2: long multi-segment blocks, gaps and stall
        add_frame(300, 200, 1'b1);
        for (int f = 0; f < 25; f++) add_frame(1 + int'($urandom % 40), 12, 1'b1);
        add_frame(33, 33, 1'b0);
        run(1'b1, 1'b1);

        check(got_err == exp_err, "R4 error pulse count", 64'(got_err), 64'(exp_err));
        check(beats_got == beats_exp, "R1 R2 total beats", 64'(beats_got), 64'(beats_exp));
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule